// File: doc/BRIEF.md
# Bus Acquisition Controller

This block lets a supervising controller take over and hand back the memory bus of an 8-bit processor. The supervisor issues one-cycle commands. The block holds the processor in reset or lets it run, asks for the bus through an active-low request line, and waits for the processor's active-low acknowledge. Only after that acknowledge arrives does it turn on the supervisor's address and strobe drivers.

Reset and bus ownership are tracked as two separate properties, which gives four states. Every wait for acknowledge is bounded by a down-counter that steps on a coarse tick. A wait that runs out is abandoned with the drivers off, and a sticky error flag is set. A separate engine performs the actual memory cycles once the drivers are on, and it reads `bus_oe` to know when it may drive.

Top module: `busacq_ctrl`

## Requirements
- R1: After `rst_n` is sampled low, the block reports state 0 and holds `cpu_rst_n` low, `bus_req_n` high, `bus_oe` low, `busy` low and `tmo_err` low.
- R2: States are encoded as follows: 0 = held in reset, 1 = held in reset with the bus owned, 2 = running, 3 = running with the bus owned. Command code 0 (Reset) moves any idle state to 0. In state 0, `cpu_rst_n` is low, `bus_req_n` is high and `bus_oe` is low.
- R3: Command code 1 (Request) in state 0 moves to state 1 and turns on `bus_oe` without lowering `bus_req_n`. In state 2, it lowers `bus_req_n` and waits. `bus_oe` rises, with state 3, only after `bus_ack_n` has been sampled low while the request is low.
- R4: Command code 2 (Release) in state 1 returns to state 0. In state 3, it raises `bus_req_n`, turns `bus_oe` off and returns to state 2.
- R5: Command code 3 (Restart) in state 2 or 3 drives `cpu_rst_n` low for exactly PULSE_CLKS cycles and leaves the state unchanged. In state 3, `bus_oe` and the request stay on throughout. In state 0, Restart releases reset and moves to state 2. In state 1, it has no effect.
- R6: Command code 4 (Renegotiate) in state 3 turns `bus_oe` off and raises `bus_req_n` for exactly BOUNCE_CLKS cycles. It then lowers the request again and turns `bus_oe` back on, staying in state 3, only after acknowledge is seen low again.
- R7: A wait for acknowledge ends after TMO_TICKS ticks of TICK_DIV clocks each if acknowledge stays high. The block then moves to state 2 with `bus_req_n` high, `bus_oe` low and `tmo_err` set.
- R8: `tmo_err` stays set until the next accepted command, which is any code 0 to 4 given while `busy` is low. That command clears it.
- R9: `busy` is high for the whole of a reset pulse, a request-high gap and an acknowledge wait. A command given while `busy` is high is ignored.
- R10: A valid command that does not apply to the current state leaves the state and outputs unchanged. Codes 5 to 7 are ignored entirely and do not clear `tmo_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd | input | 3 | Command code: 0 Reset, 1 Request, 2 Release, 3 Restart, 4 Renegotiate |
| bus_ack_n | input | 1 | Processor bus acknowledge, active low, asynchronous |
| cpu_rst_n | output | 1 | Processor reset, active low |
| bus_req_n | output | 1 | Processor bus request, active low |
| bus_oe | output | 1 | Enable for the address and MREQ/RD/WR drivers (driven high when on) |
| state_o | output | 2 | Current state code |
| busy | output | 1 | A pulse, gap or acknowledge wait is in progress |
| tmo_err | output | 1 | Sticky acknowledge-timeout flag |

## Verification
The bench goes after the following corner cases, and after a random mix of all codes with an acknowledge that either follows the request or never comes:

- **Ordering of driver enable and acknowledge.** A design that turned the drivers on early would fight the processor for the bus.
- **Exact reset-pulse and request-gap widths.** An off-by-one counter shows up as one cycle too many or too few.
- **Timeout path.** A design that forgot to drop the request would leave the processor stalled in state 2.
- **A Reset given during a wait.** A design that accepted it would land in state 0 instead of timing out in state 2.
- **Invalid codes and the stickiness of the error flag.** A design that cleared the flag on any strobe would lose the timeout report.

// File: rtl/busacq_pkg.sv
// Package: shared state, phase and command encodings for the bus acquisition
// controller. Assumes a 3-bit command code; codes above CMD_RENEG are invalid.
package busacq_pkg;

    typedef enum logic [1:0] {
        ST_RST     = 2'd0,
        ST_RST_ACQ = 2'd1,
        ST_RUN     = 2'd2,
        ST_RUN_ACQ = 2'd3
    } acq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_PULSE  = 2'd1,
        PH_BOUNCE = 2'd2,
        PH_WAIT   = 2'd3
    } acq_phase_t;

    localparam logic [2:0] CMD_RESET   = 3'd0;
    localparam logic [2:0] CMD_REQUEST = 3'd1;
    localparam logic [2:0] CMD_RELEASE = 3'd2;
    localparam logic [2:0] CMD_RESTART = 3'd3;
    localparam logic [2:0] CMD_RENEG   = 3'd4;

endpackage

// File: rtl/busacq_sync.sv
// Module: multi-stage synchronizer for the asynchronous acknowledge input.
// Assumes STAGES >= 1; every stage resets to the idle (high) level.
module busacq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop samples the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= din;
            end
        end else begin : g_next
            // Later flops shift the sample along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/busacq_width.sv
// Module: loadable down-counter that times the reset pulse and the request gap.
// Assumes load values fit in W bits; done is high while the count is zero.
module busacq_width #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/busacq_tmo.sv
// Module: acknowledge-wait timeout, made of a tick prescaler and a tick down-counter.
// Assumes TICK_DIV >= 2 and TMO_TICKS >= 1. start restarts both counters;
// counting happens only while run is high.
module busacq_tmo #(
    parameter int TICK_DIV  = 16,
    parameter int TMO_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam int TMO_W = $clog2(TMO_TICKS + 1);

    logic [PRE_W-1:0] pre;
    logic [TMO_W-1:0] left;

    // Prescale the clock to ticks and count ticks down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre  <= '0;
            left <= '0;
        end else if (start) begin
            pre  <= '0;
            left <= TMO_W'(TMO_TICKS);
        end else if (run) begin
            if (pre == PRE_W'(TICK_DIV - 1)) begin
                pre <= '0;
                if (left != '0) left <= left - 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    assign expired = (left == '0);
endmodule

// File: rtl/busacq_ctrl.sv
// Module: top of the bus acquisition controller. A four-state machine (reset x
// ownership) plus a phase register for the timed actions. Assumes cmd_valid is a
// one-cycle strobe; commands are accepted only while no phase is active.
module busacq_ctrl #(
    parameter int TICK_DIV    = 16,
    parameter int TMO_TICKS   = 4,
    parameter int PULSE_CLKS  = 6,
    parameter int BOUNCE_CLKS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd,
    input  logic       bus_ack_n,
    output logic       cpu_rst_n,
    output logic       bus_req_n,
    output logic       bus_oe,
    output logic [1:0] state_o,
    output logic       busy,
    output logic       tmo_err
);
    import busacq_pkg::*;

    localparam int WMAX = (PULSE_CLKS > BOUNCE_CLKS) ? PULSE_CLKS : BOUNCE_CLKS;
    localparam int WW   = $clog2(WMAX + 1);

    acq_state_t state;
    acq_phase_t phase;
    logic       ack_s;
    logic       accept;
    logic       w_load, w_done;
    logic [WW-1:0] w_val;
    logic       t_start, t_expired;
    logic       err_q;

    busacq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(bus_ack_n), .dout(ack_s)
    );

    busacq_width #(.W(WW)) u_width (
        .clk(clk), .rst_n(rst_n), .load(w_load), .load_val(w_val), .done(w_done)
    );

    busacq_tmo #(.TICK_DIV(TICK_DIV), .TMO_TICKS(TMO_TICKS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .start(t_start), .run(phase == PH_WAIT),
        .expired(t_expired)
    );

    // Accept a valid code only when no timed action is running.
    assign accept = cmd_valid && (phase == PH_IDLE) && (cmd <= CMD_RENEG);

    // Choose the width counter load for a reset pulse or a request gap.
    always_comb begin
        w_load = 1'b0;
        w_val  = '0;
        if (accept && cmd == CMD_RESTART &&
            (state == ST_RUN || state == ST_RUN_ACQ)) begin
            w_load = 1'b1;
            w_val  = WW'(PULSE_CLKS - 1);
        end else if (accept && cmd == CMD_RENEG && state == ST_RUN_ACQ) begin
            w_load = 1'b1;
            w_val  = WW'(BOUNCE_CLKS - 1);
        end
    end

    // Restart the timeout whenever an acknowledge wait begins.
    assign t_start = (accept && cmd == CMD_REQUEST && state == ST_RUN) ||
                     (phase == PH_BOUNCE && w_done);

    // Main state, phase and error register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RST;
            phase <= PH_IDLE;
            err_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    err_q <= 1'b0;
                    case (cmd)
                        CMD_RESET:   state <= ST_RST;
                        CMD_REQUEST: begin
                            if (state == ST_RST)      state <= ST_RST_ACQ;
                            else if (state == ST_RUN) phase <= PH_WAIT;
                        end
                        CMD_RELEASE: begin
                            if (state == ST_RST_ACQ)      state <= ST_RST;
                            else if (state == ST_RUN_ACQ) state <= ST_RUN;
                        end
                        CMD_RESTART: begin
                            if (state == ST_RST) state <= ST_RUN;
                            else if (state == ST_RUN || state == ST_RUN_ACQ)
                                phase <= PH_PULSE;
                        end
                        CMD_RENEG: if (state == ST_RUN_ACQ) phase <= PH_BOUNCE;
                        default: ;
                    endcase
                end
                PH_PULSE:  if (w_done) phase <= PH_IDLE;
                PH_BOUNCE: if (w_done) phase <= PH_WAIT;
                PH_WAIT: begin
                    if (!ack_s) begin
                        state <= ST_RUN_ACQ;
                        phase <= PH_IDLE;
                    end else if (t_expired) begin
                        state <= ST_RUN;
                        phase <= PH_IDLE;
                        err_q <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Pin levels decoded from state and phase.
    assign cpu_rst_n = (state == ST_RUN || state == ST_RUN_ACQ) && (phase != PH_PULSE);
    assign bus_req_n = !((phase == PH_WAIT) ||
                         (state == ST_RUN_ACQ && phase != PH_BOUNCE));
    assign bus_oe    = (state == ST_RST_ACQ) ||
                       (state == ST_RUN_ACQ && (phase == PH_IDLE || phase == PH_PULSE));
    assign state_o   = state;
    assign busy      = (phase != PH_IDLE);
    assign tmo_err   = err_q;
endmodule

// File: rtl/busacq_chk.sv
// Module: assertion checker for busacq_ctrl, attached by bind. It watches the
// ports only and keeps a flag recording whether acknowledge was seen low
// while the request was low.
module busacq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_ack_n,
    input logic       cpu_rst_n,
    input logic       bus_req_n,
    input logic       bus_oe,
    input logic [1:0] state_o,
    input logic       busy,
    input logic       tmo_err
);
    logic lo_seen;

    // Track whether acknowledge was sampled low since the request last went low.
    always_ff @(posedge clk) begin
        if (!rst_n)          lo_seen <= 1'b0;
        else if (bus_req_n)  lo_seen <= 1'b0;
        else if (!bus_ack_n) lo_seen <= 1'b1;
    end

    a_r2_reset_state_pins: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd0 |-> (!cpu_rst_n && bus_req_n && !bus_oe && !busy));

    a_r3_oe_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_oe) && state_o == 2'd3) |-> lo_seen);

    a_r3_oe_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && state_o == 2'd3) |-> !bus_req_n);

    a_r4_release_drops_oe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_n) |-> !bus_oe);

    a_r7_timeout_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err) |-> ($fell(busy) && bus_req_n && !bus_oe && state_o == 2'd2));

    a_r9_pulse_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rst_n && state_o[1]) |-> busy);
endmodule

bind busacq_ctrl busacq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_ack_n(bus_ack_n), .cpu_rst_n(cpu_rst_n),
    .bus_req_n(bus_req_n), .bus_oe(bus_oe), .state_o(state_o), .busy(busy),
    .tmo_err(tmo_err)
);

// File: tb/tb_busacq_ctrl.sv
// Bench: directed corner cases plus a seeded random command mix. A modelled
// processor answers the request one cycle later, or never when unresponsive.
module tb_busacq_ctrl;
    localparam int TICK_DIV    = 16;
    localparam int TMO_TICKS   = 4;
    localparam int PULSE_CLKS  = 6;
    localparam int BOUNCE_CLKS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic bus_ack_n = 1'b1;
    logic cpu_rst_n, bus_req_n, bus_oe, busy, tmo_err;
    logic [1:0] state_o;

    int errors = 0;
    int checks = 0;
    bit resp = 1'b1;
    logic req_d = 1'b1;
    bit done = 1'b0;

    always #5 clk = ~clk;

    busacq_ctrl #(.TICK_DIV(TICK_DIV), .TMO_TICKS(TMO_TICKS), .PULSE_CLKS(PULSE_CLKS),
                  .BOUNCE_CLKS(BOUNCE_CLKS), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .bus_ack_n(bus_ack_n), .cpu_rst_n(cpu_rst_n), .bus_req_n(bus_req_n),
        .bus_oe(bus_oe), .state_o(state_o), .busy(busy), .tmo_err(tmo_err)
    );

    function automatic logic [1:0] nxt_state(logic [1:0] st, logic [2:0] c, bit r);
        case (c)
            3'd0: return 2'd0;
            3'd1: return (st == 2'd0) ? 2'd1 : (st == 2'd2) ? (r ? 2'd3 : 2'd2) : st;
            3'd2: return (st == 2'd1) ? 2'd0 : (st == 2'd3) ? 2'd2 : st;
            3'd3: return (st == 2'd0) ? 2'd2 : st;
            3'd4: return (st == 2'd3) ? (r ? 2'd3 : 2'd2) : st;
            default: return st;
        endcase
    endfunction

    function automatic logic nxt_err(logic [1:0] st, logic [2:0] c, bit r, logic e);
        if (c > 3'd4) return e;
        return ((c == 3'd1 && st == 2'd2) || (c == 3'd4 && st == 2'd3)) && !r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: wait for the falling edge, then update the processor model.
    task automatic tick();
        @(negedge clk);
        bus_ack_n = resp ? req_d : 1'b1;
        req_d = bus_req_n;
    endtask

    task automatic issue(logic [2:0] c);
        cmd_valid = 1'b1;
        cmd = c;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic settle();
        int n = 0;
        while (busy && n < 2000) begin tick(); n++; end
        if (busy) check("R9 busy never ended", 1, 0);
        repeat (3) tick();
    endtask

    task automatic check_pins(string tag, logic [1:0] st, logic e);
        check({tag, " state"}, state_o, st);
        check({tag, " cpu_rst_n"}, cpu_rst_n, st[1]);
        check({tag, " bus_req_n"}, bus_req_n, st != 2'd3);
        check({tag, " bus_oe"}, bus_oe, st == 2'd1 || st == 2'd3);
        check({tag, " tmo_err"}, tmo_err, e);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] st;
        logic e;
        int n;
        void'($urandom(32'd2718));
        repeat (4) tick();
        // R1: reset state.
        check_pins("R1 reset", 2'd0, 1'b0);
        check("R1 busy", busy, 0);
        rst_n = 1'b1;
        tick();

        // R3: Request while held in reset takes the bus without asserting request.
        issue(3'd1); settle(); check_pins("R3 req in reset", 2'd1, 0);
        // R5: Restart in state 1 is ignored.
        issue(3'd3); settle(); check_pins("R5 restart ignored in 1", 2'd1, 0);
        issue(3'd2); settle(); check_pins("R4 release to 0", 2'd0, 0);
        issue(3'd3); settle(); check_pins("R5 restart from 0 runs", 2'd2, 0);

        // R5: reset pulse width in the running state.
        issue(3'd3);
        n = 0;
        while (!cpu_rst_n && n < 100) begin n++; tick(); end
        check("R5 pulse width", n, PULSE_CLKS);
        settle(); check_pins("R5 after pulse", 2'd2, 0);

        // R3: Request in the running state; drivers stay off until acknowledge is seen.
        resp = 1'b1;
        issue(3'd1);
        check("R3 oe off during wait", bus_oe, 0);
        check("R3 request low during wait", bus_req_n, 0);
        settle(); check_pins("R3 acquired", 2'd3, 0);

        // R5: pulse while owning the bus keeps the drivers on.
        issue(3'd3);
        check("R5 oe kept in pulse", bus_oe, 1);
        check("R5 reset low in pulse", cpu_rst_n, 0);
        settle(); check_pins("R5 restart keeps bus", 2'd3, 0);

        // R6: renegotiate gap width, drivers off during it.
        issue(3'd4);
        n = 0;
        while (bus_req_n && n < 100) begin
            if (bus_oe) check("R6 oe during gap", bus_oe, 0);
            n++; tick();
        end
        check("R6 gap width", n, BOUNCE_CLKS);
        settle(); check_pins("R6 reacquired", 2'd3, 0);

        // R4: Release from state 3.
        issue(3'd2); settle(); check_pins("R4 release to 2", 2'd2, 0);

        // R7 and R9: no acknowledge; a Reset given mid-wait must be ignored.
        resp = 1'b0;
        issue(3'd1);
        repeat (3) tick();
        check("R9 busy in wait", busy, 1);
        issue(3'd0);
        settle(); check_pins("R7 timeout", 2'd2, 1);

        // R10: invalid code keeps the error; R8: an accepted no-op command clears it.
        issue(3'd6); settle(); check_pins("R10 invalid code", 2'd2, 1);
        issue(3'd2); settle(); check_pins("R8 cleared by no-op", 2'd2, 0);
        issue(3'd0); settle(); check_pins("R2 reset command", 2'd0, 0);

        // Random mix checked against the bench model.
        st = 2'd0; e = 1'b0;
        for (int i = 0; i < 150; i++) begin
            logic [2:0] c;
            c = 3'($urandom_range(0, 7));
            resp = ($urandom_range(0, 3) != 0);
            issue(c);
            settle();
            e = nxt_err(st, c, resp, e);
            st = nxt_state(st, c, resp);
            check_pins($sformatf("R2 R10 random cmd %0d", c), st, e);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule